// File: doc/BRIEF.md
# Jumper-Configured Memory Region Decoder

This block sits between the top bits of a CPU address bus (A23 down to A17) and a shared DRAM controller. For each address it decides whether the access falls in a memory window. If it does, it drives an active-low RAM-enable strobe and one of two active-low row-strobe outputs. The shared region occupies the bottom two megabytes. An optional extra window at 0xC00000–0xC7FFFF can also be enabled.

Two static board-option inputs shape the map. One option turns the extra high window on or off. The other option picks which address bit acts as the bank-select: A23 puts bank 1 at the high window, and A19 puts bank 1 directly above bank 0 in the low region. Both options are captured while reset is held and are frozen once reset is released. The setting that combines A19 bank-select with the high window enabled maps the memory in two conflicting ways, and the block flags it.

All outputs come from a register. They reflect the address and strobe that were present at the previous rising clock edge. The block has no data path and no handshaking of its own; every pin is a plain level.

Top module: `mem_region_decoder`

## Requirements
- R1: With the address strobe active (low) and A23..A21 = 000 (0x000000–0x1FFFFF), `ram_en_n` is low in the cycle after the edge that sampled the address.
- R2: An address with A23..A19 = 11000 (0xC00000–0xC7FFFF) drives `ram_en_n` low only when the window option was captured as 1. When the option was captured as 0, the same address gives `no_ram` = 1 and `ram_en_n` = 1.
- R3: With the bank option captured as 0, the bank bit is A23. `ras_n` = 2'b10 (bit 0 low) for bank 0, and `ras_n` = 2'b01 for bank 1.
- R4: With the bank option captured as 1, the bank bit is A19. So 0x000000–0x07FFFF gives `ras_n` = 2'b10, and 0x080000–0x0FFFFF gives `ras_n` = 2'b01.
- R5: At most one bit of `ras_n` is low at a time. A `ras_n` bit is low only when `ram_en_n` is also low.
- R6: While the strobe `cpu_as_n` is high, the next outputs are idle: `ram_en_n` = 1, `ras_n` = 2'b11, `no_ram` = 0.
- R7: `config_error` is 1 exactly when the captured options are bank option = 1 and window option = 1.
- R8: The options are sampled at every rising edge while `rst_n` is low. Changes on the option inputs after reset release have no effect on any output.
- R9: With the strobe active and the address outside every enabled window, `no_ram` = 1, `ram_en_n` = 1 and `ras_n` = 2'b11.
- R10: While `rst_n` is low, the outputs are `ram_en_n` = 1, `ras_n` = 2'b11 and `no_ram` = 0.
- R11: The decode has one cycle of latency. A new address or strobe value does not affect the outputs before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the options are captured while it is low |
| cpu_addr_hi | input | 7 | CPU address bits A23..A17 (bit 6 = A23) |
| cpu_as_n | input | 1 | Active-low address strobe |
| opt_win_en | input | 1 | Board option: 1 enables the 0xC0–0xC7 window |
| opt_bank_alt | input | 1 | Board option: 0 selects A23 as the bank bit, 1 selects A19 |
| ram_en_n | output | 1 | Active-low RAM-enable for the memory controller |
| ras_n | output | 2 | Active-low row strobes; bit 0 = bank 0, bit 1 = bank 1 |
| no_ram | output | 1 | Strobed access hit no enabled window |
| config_error | output | 1 | Captured options describe a conflicting map |

## Verification
The assertions assume that reset is asserted from time zero. They compare outputs against the address and strobe one cycle earlier, and they accept any address pattern. They also assume that the captured options never change outside reset, and they check this as well. The stimulus drives inputs only on falling edges. It runs every option combination through its own reset. It also deliberately toggles the option inputs after reset, which is legal because only the captured copies feed the decode.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  typedef enum logic {
    BANK_FROM_TOP = 1'b0,
    BANK_FROM_ALT = 1'b1
  } bank_src_e;

  typedef struct packed {
    logic      win_en;
    bank_src_e bank_src;
  } mrd_cfg_t;

  typedef struct packed {
    logic hit;
    logic bank;
  } mrd_dec_t;

endpackage

// File: rtl/mrd_cfg_latch.sv
module mrd_cfg_latch
  import mrd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     win_en_in,
  input  logic     bank_alt_in,
  output mrd_cfg_t cfg_q,
  output logic     cfg_bad_q
);

  // Options track the pins only while reset is held, then freeze.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.win_en   <= win_en_in;
      cfg_q.bank_src <= bank_src_e'(bank_alt_in);
      cfg_bad_q      <= win_en_in & bank_alt_in;
    end
  end

endmodule

// File: rtl/mrd_window_decode.sv
module mrd_window_decode
  import mrd_pkg::*;
#(
  parameter int AW = 7,
  parameter int ALT_IDX = 2,
  parameter logic [AW-1:0] CHIP_MASK  = 7'b1110000,
  parameter logic [AW-1:0] CHIP_MATCH = 7'b0000000,
  parameter logic [AW-1:0] WIN_MASK   = 7'b1111100,
  parameter logic [AW-1:0] WIN_MATCH  = 7'b1100000
) (
  input  logic [AW-1:0] addr,
  input  mrd_cfg_t      cfg,
  output mrd_dec_t      dec
);

  logic chip_hit;
  logic win_hit;

  always_comb begin
    chip_hit = ((addr ^ CHIP_MATCH) & CHIP_MASK) == '0;
    win_hit  = (((addr ^ WIN_MATCH) & WIN_MASK) == '0) && cfg.win_en;
    dec.hit  = chip_hit | win_hit;
    dec.bank = (cfg.bank_src == BANK_FROM_ALT) ? addr[ALT_IDX] : addr[AW-1];
  end

endmodule

// File: rtl/mrd_strobe_gen.sv
module mrd_strobe_gen
  import mrd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       as_n,
  input  mrd_dec_t   dec,
  output logic       ram_en_n,
  output logic [1:0] ras_n,
  output logic       no_ram
);

  localparam int NBANK = 2;

  logic access;
  assign access = ~as_n & dec.hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_en_n <= 1'b1;
      no_ram   <= 1'b0;
    end else begin
      ram_en_n <= ~access;
      no_ram   <= ~as_n & ~dec.hit;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_ras
    always_ff @(posedge clk) begin
      if (!rst_n) ras_n[b] <= 1'b1;
      else        ras_n[b] <= ~(access && (dec.bank == b[0]));
    end
  end

endmodule

// File: rtl/mem_region_decoder.sv
module mem_region_decoder
  import mrd_pkg::*;
#(
  parameter int TOP_BIT = 23,
  parameter int LOW_BIT = 17,
  parameter int ALT_BANK_BIT = 19,
  parameter logic [TOP_BIT-LOW_BIT:0] CHIP_MASK  = 7'b1110000,
  parameter logic [TOP_BIT-LOW_BIT:0] CHIP_MATCH = 7'b0000000,
  parameter logic [TOP_BIT-LOW_BIT:0] WIN_MASK   = 7'b1111100,
  parameter logic [TOP_BIT-LOW_BIT:0] WIN_MATCH  = 7'b1100000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TOP_BIT-LOW_BIT:0] cpu_addr_hi,
  input  logic                     cpu_as_n,
  input  logic                     opt_win_en,
  input  logic                     opt_bank_alt,
  output logic                     ram_en_n,
  output logic [1:0]               ras_n,
  output logic                     no_ram,
  output logic                     config_error
);

  localparam int AW = TOP_BIT - LOW_BIT + 1;
  localparam int ALT_IDX = ALT_BANK_BIT - LOW_BIT;

  mrd_cfg_t cfg_q;
  mrd_dec_t dec;
  logic     win_en_q;
  logic     bank_alt_q;

  assign win_en_q   = cfg_q.win_en;
  assign bank_alt_q = (cfg_q.bank_src == BANK_FROM_ALT);

  mrd_cfg_latch u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_en_in  (opt_win_en),
    .bank_alt_in(opt_bank_alt),
    .cfg_q      (cfg_q),
    .cfg_bad_q  (config_error)
  );

  mrd_window_decode #(
    .AW        (AW),
    .ALT_IDX   (ALT_IDX),
    .CHIP_MASK (CHIP_MASK),
    .CHIP_MATCH(CHIP_MATCH),
    .WIN_MASK  (WIN_MASK),
    .WIN_MATCH (WIN_MATCH)
  ) u_dec (
    .addr(cpu_addr_hi),
    .cfg (cfg_q),
    .dec (dec)
  );

  mrd_strobe_gen u_stb (
    .clk     (clk),
    .rst_n   (rst_n),
    .as_n    (cpu_as_n),
    .dec     (dec),
    .ram_en_n(ram_en_n),
    .ras_n   (ras_n),
    .no_ram  (no_ram)
  );

endmodule

// File: rtl/mrd_checker.sv
module mrd_checker #(
  parameter int AW = 7,
  parameter int ALT_IDX = 2,
  parameter logic [AW-1:0] CHIP_MASK  = 7'b1110000,
  parameter logic [AW-1:0] CHIP_MATCH = 7'b0000000,
  parameter logic [AW-1:0] WIN_MASK   = 7'b1111100,
  parameter logic [AW-1:0] WIN_MATCH  = 7'b1100000
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cpu_addr_hi,
  input logic          cpu_as_n,
  input logic          ram_en_n,
  input logic [1:0]    ras_n,
  input logic          no_ram,
  input logic          config_error,
  input logic          win_en_q,
  input logic          bank_alt_q
);

  logic up_q;
  always_ff @(posedge clk) up_q <= rst_n;

  logic in_chip, in_win;
  assign in_chip = ((cpu_addr_hi ^ CHIP_MATCH) & CHIP_MASK) == '0;
  assign in_win  = ((cpu_addr_hi ^ WIN_MATCH) & WIN_MASK) == '0;

  // R1
  a_r1_chip_enables: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    (!$past(cpu_as_n) && $past(in_chip)) |-> !ram_en_n);

  // R2
  a_r2_window_follows_option: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    (!$past(cpu_as_n) && $past(in_win)) |-> (ram_en_n == !win_en_q));

  // R3
  a_r3_top_bit_bank: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    (!$past(cpu_as_n) && $past(in_chip) && !bank_alt_q) |-> (ras_n == 2'b10));

  // R4
  a_r4_alt_bit_bank: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    (!$past(cpu_as_n) && $past(in_chip) && bank_alt_q)
      |-> (ras_n == ($past(cpu_addr_hi[ALT_IDX]) ? 2'b01 : 2'b10)));

  // R5
  a_r5_one_row_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ras_n));
  a_r5_row_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n != 2'b11) |-> !ram_en_n);

  // R6
  a_r6_idle_without_strobe: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    $past(cpu_as_n) |-> (ram_en_n && ras_n == 2'b11 && !no_ram));

  // R7
  a_r7_error_only_conflict: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    config_error |-> (win_en_q && bank_alt_q));

  // R8
  a_r8_options_frozen: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    $stable(win_en_q) && $stable(bank_alt_q) && $stable(config_error));

  // R9
  a_r9_miss_flagged: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    (!$past(cpu_as_n) && !$past(in_chip) && !$past(in_win))
      |-> (no_ram && ram_en_n && ras_n == 2'b11));

endmodule

bind mem_region_decoder mrd_checker #(
  .AW        (AW),
  .ALT_IDX   (ALT_IDX),
  .CHIP_MASK (CHIP_MASK),
  .CHIP_MATCH(CHIP_MATCH),
  .WIN_MASK  (WIN_MASK),
  .WIN_MATCH (WIN_MATCH)
) u_chk (.*);

// File: tb/mem_region_decoder_tb_top.sv
module mem_region_decoder_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] cpu_addr_hi = '0;
  logic       cpu_as_n = 1'b1;
  logic       opt_win_en = 1'b0;
  logic       opt_bank_alt = 1'b0;
  logic       ram_en_n;
  logic [1:0] ras_n;
  logic       no_ram;
  logic       config_error;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mem_region_decoder dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr_hi (cpu_addr_hi),
    .cpu_as_n    (cpu_as_n),
    .opt_win_en  (opt_win_en),
    .opt_bank_alt(opt_bank_alt),
    .ram_en_n    (ram_en_n),
    .ras_n       (ras_n),
    .no_ram      (no_ram),
    .config_error(config_error)
  );

  // Expected {ram_en_n, ras_n[1], ras_n[0], no_ram}
  function automatic logic [3:0] model(input logic [6:0] a, input logic as_n,
                                       input logic win, input logic alt);
    logic chip, hw, hit, bank;
    chip = (a[6:4] == 3'b000);
    hw   = (a[6:2] == 5'b11000);
    hit  = chip | (win & hw);
    bank = alt ? a[2] : a[6];
    if (as_n) return 4'b1110;
    if (!hit) return 4'b1111;
    return bank ? 4'b0010 : 4'b0100;
  endfunction

  function automatic string tag_of(input logic [6:0] a, input logic as_n, input logic alt);
    if (as_n) return "R6";
    if (a[6:2] == 5'b11000) return "R2";
    if (a[6:4] != 3'b000) return "R9";
    return alt ? "R4" : "R3";
  endfunction

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: outputs actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic win, input logic alt);
    @(negedge clk);
    rst_n = 1'b0;
    cpu_as_n = 1'b1;
    opt_win_en = win;
    opt_bank_alt = alt;
    repeat (3) @(negedge clk);
    check("R10", {ram_en_n, ras_n, no_ram}, 4'b1110);
    rst_n = 1'b1;
  endtask

  // Drive at a falling edge, compare at the next falling edge.
  task automatic access(input logic [6:0] a, input logic as_n,
                        input logic win, input logic alt, input string req);
    cpu_addr_hi = a;
    cpu_as_n = as_n;
    @(negedge clk);
    check(req, {ram_en_n, ras_n, no_ram}, model(a, as_n, win, alt));
  endtask

  initial begin
    void'($urandom(32'h0005_eed1));
    for (int c = 0; c < 4; c++) begin
      logic win, alt;
      win = c[0];
      alt = c[1];
      do_reset(win, alt);
      check_bit("R7", config_error, win & alt);
      // Directed boundaries
      access(7'h00, 1'b0, win, alt, "R1");
      access(7'h0F, 1'b0, win, alt, "R1");
      access(7'h10, 1'b0, win, alt, "R9");
      access(7'h03, 1'b0, win, alt, alt ? "R4" : "R3");
      access(7'h04, 1'b0, win, alt, alt ? "R4" : "R3");
      access(7'h60, 1'b0, win, alt, "R2");
      access(7'h63, 1'b0, win, alt, "R2");
      access(7'h64, 1'b0, win, alt, "R9");
      access(7'h7F, 1'b0, win, alt, "R9");
      access(7'h00, 1'b1, win, alt, "R6");
      // R11: a new address shows nothing before the next rising edge
      cpu_addr_hi = 7'h00;
      cpu_as_n = 1'b0;
      #1;
      check("R11", {ram_en_n, ras_n, no_ram}, 4'b1110);
      @(negedge clk);
      check("R11", {ram_en_n, ras_n, no_ram}, model(7'h00, 1'b0, win, alt));
      // Random mix
      for (int i = 0; i < 300; i++) begin
        logic [6:0] a;
        logic s;
        case ($urandom % 4)
          0: a = 7'($urandom);
          1: a = {3'b000, 4'($urandom)};
          2: a = {5'b11000, 2'($urandom)};
          default: a = 7'($urandom);
        endcase
        s = ($urandom % 5) == 0;
        access(a, s, win, alt, tag_of(a, s, alt));
      end
      // R8: option pins flipped after release are ignored
      opt_win_en = ~win;
      opt_bank_alt = ~alt;
      access(7'h60, 1'b0, win, alt, "R8");
      access(7'h04, 1'b0, win, alt, "R8");
      check_bit("R8", config_error, win & alt);
      access(7'h00, 1'b1, win, alt, "R6");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 150000; k++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule